// File: doc/BRIEF.md
# Dual-Source Supply Switch Controller

This block decides whether the chip runs from its battery or from energy taken out of a coil field. Two comparator flags arrive as digital inputs: one says the rectified coil voltage sits above the field-on level, the other says it sits below the field-off level. A free-running timebase strobe (`tick`, one pulse per microsecond by default) is the unit for every delay. The block qualifies each flag with a low-pass dwell: the flag must hold through a run of ticks, and any drop restarts the count. The two directions use different dwell lengths: a short one to enter field supply and a long one to leave it.

The block drives a supply-select output and a wake output for the attached controller's interrupt input. It also controls an open-drain reset line. The line is pulled low after power-on and on every fall-back from field to battery. A low driven on that line from outside is folded into the reset seen by the core logic. A command strobe switches automatic mode off or on. While automatic mode is off, the block stays on battery until an on-command or a power-on reset. The command and control pins are plain level and strobe signals, not streams, so there is no back-pressure at the edge of the block.

Top module: `supply_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, `sel_field` and `wake` are 0, `nrst_oe` is 1, `rst_to_core` is 1, and automatic mode is set to on.
- R2: After `rst_n` rises, `nrst_oe` stays 1 through the first RST_TICKS clock edges at which `tick` is high. It falls at the RST_TICKS-th such edge.
- R3: From battery with automatic mode on, `sel_field` rises at the clock edge where `coil_above_on` is still high after having been high at ON_DWELL earlier consecutive tick edges. With `tick` held high, that is the (ON_DWELL+1)-th edge after the flag rises. No battery-validity input gates this switch.
- R4: A low sample of `coil_above_on` before the dwell completes restarts the count from zero. A glitch therefore causes no switch and no wake.
- R5: Dwell counts advance only on edges with `tick` high. With `tick` low, a flag held for any number of clocks causes no switch.
- R6: From field supply, `sel_field` falls at the (OFF_DWELL+1)-th edge of `coil_below_off` held high, with `tick` held high. A low sample restarts that count.
- R7: At the edge where `sel_field` falls, `nrst_oe` rises. It stays 1 for exactly RST_TICKS tick edges.
- R8: `wake` is 1 exactly while field supply is selected.
- R9: `cmd_valid` with `cmd_auto_en`=0 turns automatic mode off. If the block is on field supply, it returns to battery at that same edge and starts a reset pulse as in R7. While the mode is off, `coil_above_on` never selects field supply.
- R10: `cmd_valid` with `cmd_auto_en`=1 turns automatic mode back on, and so does a power-on reset. The dwell starts counting only after the command edge.
- R11: A low level on `nrst_in` makes `rst_to_core` 1 at the second clock edge after it appears. It leaves `sel_field` and the automatic mode unchanged. `rst_to_core` clears at the second edge after `nrst_in` returns high.
- R12: `rst_to_core` is 1 whenever `nrst_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Timebase strobe; one pulse is one dwell/reset unit |
| coil_above_on | input | 1 | Comparator: coil voltage above the field-on level |
| coil_below_off | input | 1 | Comparator: coil voltage below the field-off level |
| cmd_valid | input | 1 | One-cycle strobe carrying a mode command |
| cmd_auto_en | input | 1 | Command value: 1 = automatic mode on, 0 = locked to battery |
| nrst_in | input | 1 | Sampled level of the shared open-drain reset line |
| sel_field | output | 1 | 1 = field supply selected, 0 = battery |
| wake | output | 1 | Field-present wake/interrupt flag |
| nrst_oe | output | 1 | 1 = pull the shared reset line low |
| rst_to_core | output | 1 | Reset to the on-chip digital logic, active high |

## Verification
The switching function is exercised with four input patterns. A clean hold of each flag shows the exact edge of each transition. A hold that drops one edge short, then a resumed hold, tells a restarting counter apart from one that only pauses or keeps counting. Holding the flag with the timebase stopped separates tick counting from clock counting. Off and on commands sent while the coil flag is held show whether the lock masks the field path and whether re-enabling starts a fresh dwell. An outside low on the reset line is shown to reach the core reset without disturbing the supply choice.

// File: rtl/supply_sw_pkg.sv
package supply_sw_pkg;
  typedef enum logic {
    SRC_BATT  = 1'b0,
    SRC_FIELD = 1'b1
  } src_e;
endpackage

// File: rtl/dwell_qualifier.sv
// Counts tick edges while cond holds; any low sample clears the count.
// done is raised while cond is still high after LIMIT counted ticks.
module dwell_qualifier #(
  parameter int LIMIT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!cond) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = cond && (cnt_q == LIM);
endmodule

// File: rtl/reset_stretcher.sv
// Holds active for TICKS tick edges after start or after power-on reset.
module reset_stretcher #(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= LOAD;
    end else if (start) begin
      left_q <= LOAD;
    end else if (tick && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/level_sync.sv
module level_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RESET_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl #(
  parameter int ON_DWELL    = 30,
  parameter int OFF_DWELL   = 10000,
  parameter int RST_TICKS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic coil_above_on,
  input  logic coil_below_off,
  input  logic cmd_valid,
  input  logic cmd_auto_en,
  input  logic nrst_in,
  output logic sel_field,
  output logic wake,
  output logic nrst_oe,
  output logic rst_to_core
);
  import supply_sw_pkg::*;

  src_e src_q, src_d;
  logic auto_en_q;
  logic force_batt, on_cond, off_cond, on_done, off_done, fallback;
  logic rst_active, line_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         auto_en_q <= 1'b1;
    else if (cmd_valid) auto_en_q <= cmd_auto_en;
  end

  assign force_batt = cmd_valid && !cmd_auto_en;
  assign on_cond    = coil_above_on && auto_en_q && (src_q == SRC_BATT);
  assign off_cond   = coil_below_off && (src_q == SRC_FIELD);

  dwell_qualifier #(.LIMIT(ON_DWELL)) u_on_dwell (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(on_cond), .done(on_done)
  );

  dwell_qualifier #(.LIMIT(OFF_DWELL)) u_off_dwell (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cond(off_cond), .done(off_done)
  );

  always_comb begin
    src_d = src_q;
    unique case (src_q)
      SRC_BATT:  if (on_done && !force_batt)  src_d = SRC_FIELD;
      SRC_FIELD: if (off_done || force_batt)  src_d = SRC_BATT;
      default:   src_d = SRC_BATT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_BATT;
    else        src_q <= src_d;
  end

  assign fallback = (src_q == SRC_FIELD) && (src_d == SRC_BATT);

  reset_stretcher #(.TICKS(RST_TICKS)) u_rst_pulse (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(fallback), .active(rst_active)
  );

  level_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .d(nrst_in), .q(line_level)
  );

  assign sel_field   = (src_q == SRC_FIELD);
  assign wake        = (src_q == SRC_FIELD);
  assign nrst_oe     = rst_active;
  assign rst_to_core = rst_active || !line_level;
endmodule

// File: rtl/supply_switch_chk.sv
module supply_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic coil_above_on,
  input logic coil_below_off,
  input logic cmd_valid,
  input logic cmd_auto_en,
  input logic nrst_in,
  input logic sel_field,
  input logic wake,
  input logic nrst_oe,
  input logic rst_to_core
);
  // Shadow of the command lock, rebuilt from the command port alone.
  logic locked_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         locked_q <= 1'b0;
    else if (cmd_valid) locked_q <= !cmd_auto_en;
  end

  p_field_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_field) |-> $past(coil_above_on));

  p_fallback_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_field) |-> ($past(coil_below_off) || $past(cmd_valid && !cmd_auto_en)));

  p_fallback_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_field) |-> nrst_oe);

  p_lock_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_field) |-> !$past(locked_q));

  p_core_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    nrst_oe |-> rst_to_core);
endmodule

bind supply_switch_ctrl supply_switch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .coil_above_on(coil_above_on),
  .coil_below_off(coil_below_off), .cmd_valid(cmd_valid), .cmd_auto_en(cmd_auto_en),
  .nrst_in(nrst_in), .sel_field(sel_field), .wake(wake), .nrst_oe(nrst_oe),
  .rst_to_core(rst_to_core)
);

// File: tb/sim_supply_switch_ctrl.sv
`timescale 1ns/1ps
module sim_supply_switch_ctrl;
  localparam int ON_D  = 4;
  localparam int OFF_D = 6;
  localparam int RST_T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic above = 1'b0, below = 1'b0, cv = 1'b0, cen = 1'b0, line = 1'b1;
  logic sel_field, wake, nrst_oe, rst_to_core;
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  supply_switch_ctrl #(.ON_DWELL(ON_D), .OFF_DWELL(OFF_D), .RST_TICKS(RST_T)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .coil_above_on(above),
    .coil_below_off(below), .cmd_valid(cv), .cmd_auto_en(cen), .nrst_in(line),
    .sel_field(sel_field), .wake(wake), .nrst_oe(nrst_oe), .rst_to_core(rst_to_core)
  );

  // {above, below, cmd_valid, cmd_auto_en, edges[7:0], 2'b00, exp_sel, exp_oe}
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    {4'b1000, 8'd4,  2'b00, 2'b00},  // dwell not yet complete
    {4'b1000, 8'd1,  2'b00, 2'b10},  // R3 switch to field
    {4'b0100, 8'd6,  2'b00, 2'b10},
    {4'b0100, 8'd1,  2'b00, 2'b01},  // R6 back to battery, R7 pulse
    {4'b0000, 8'd2,  2'b00, 2'b01},
    {4'b0000, 8'd1,  2'b00, 2'b00},  // R7 pulse width
    {4'b1000, 8'd3,  2'b00, 2'b00},  // R4 glitch
    {4'b0000, 8'd1,  2'b00, 2'b00},
    {4'b1000, 8'd4,  2'b00, 2'b00},  // R4 restarted
    {4'b1000, 8'd1,  2'b00, 2'b10},
    {4'b0100, 8'd5,  2'b00, 2'b10},  // R6 glitch
    {4'b0000, 8'd1,  2'b00, 2'b10},
    {4'b0100, 8'd6,  2'b00, 2'b10},
    {4'b0100, 8'd1,  2'b00, 2'b01},
    {4'b0000, 8'd3,  2'b00, 2'b00},
    {4'b1000, 8'd5,  2'b00, 2'b10},
    {4'b1010, 8'd1,  2'b00, 2'b01},  // R9 off command in field
    {4'b1000, 8'd20, 2'b00, 2'b00},  // R9 locked
    {4'b1011, 8'd1,  2'b00, 2'b00},  // R10 on command
    {4'b1000, 8'd4,  2'b00, 2'b00},
    {4'b1000, 8'd1,  2'b00, 2'b10},  // R10 switch after fresh dwell
    {4'b1010, 8'd1,  2'b00, 2'b01},  // R9 off again
    {4'b1000, 8'd10, 2'b00, 2'b00}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sel_field in reset", sel_field, 1'b0);
    chk("R1 wake in reset", wake, 1'b0);
    chk("R1 nrst_oe in reset", nrst_oe, 1'b1);
    chk("R1 rst_to_core in reset", rst_to_core, 1'b1);
    rst_n = 1'b1;
    edges(RST_T - 1);
    chk("R2 power-on pulse held", nrst_oe, 1'b1);
    edges(1);
    chk("R2 power-on pulse ended", nrst_oe, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {above, below, cv, cen} = VEC[i][15:12];
      edges(int'(VEC[i][11:4]));
      cv = 1'b0;
      chk($sformatf("R3 R4 R6 R9 R10 row %0d sel_field", i), sel_field, VEC[i][1]);
      chk($sformatf("R7 row %0d nrst_oe", i), nrst_oe, VEC[i][0]);
      chk($sformatf("R8 row %0d wake", i), wake, VEC[i][1]);
      if (VEC[i][0]) chk($sformatf("R12 row %0d rst_to_core", i), rst_to_core, 1'b1);
    end

    // R5: ticks, not clocks, advance the dwell
    above = 1'b0; cv = 1'b1; cen = 1'b1;
    edges(1);
    cv = 1'b0; tick = 1'b0; above = 1'b1;
    edges(30);
    chk("R5 no switch without ticks", sel_field, 1'b0);
    tick = 1'b1;
    edges(ON_D);
    chk("R5 dwell counted from ticks", sel_field, 1'b0);
    edges(1);
    chk("R5 switch after ticks", sel_field, 1'b1);

    // R11: outside low on reset line
    line = 1'b0;
    edges(1);
    chk("R11 sync delay", rst_to_core, 1'b0);
    edges(1);
    chk("R11 core reset from line", rst_to_core, 1'b1);
    chk("R11 supply unchanged", sel_field, 1'b1);
    line = 1'b1;
    edges(1);
    chk("R11 release delay", rst_to_core, 1'b1);
    edges(1);
    chk("R11 core reset released", rst_to_core, 1'b0);

    // R10: power-on reset clears the lock
    cv = 1'b1; cen = 1'b0;
    edges(1);
    cv = 1'b0;
    chk("R9 off in field", sel_field, 1'b0);
    edges(8);
    rst_n = 1'b0; above = 1'b0;
    edges(2);
    chk("R1 reset state again", nrst_oe, 1'b1);
    rst_n = 1'b1;
    edges(RST_T + 2);
    above = 1'b1;
    edges(ON_D);
    chk("R10 dwell after power-on", sel_field, 1'b0);
    edges(1);
    chk("R10 lock cleared by power-on", sel_field, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule